// File: doc/BRIEF.md
# Request-to-Send / Clear-to-Send Delay Controller

This block turns an active-low request-to-send from the terminal side into an active-low clear-to-send, with a programmable turn-on delay. The delay is counted in ticks of a slow enable. The enable comes from dividing the master clock by a power of two. With a 3.579545 MHz master clock and a 12-bit divider the tick rate is about 873.9 Hz. A two-bit select picks one of the built-in delays. A table per line standard maps each select value to a tick count.

Turn-off needs no timer: clear-to-send is withdrawn in the same cycle that the request is withdrawn. The select value 2'b11 bypasses the internal timer, and clear-to-send then follows a request input that an external delay circuit has already delayed. In loop-test mode the request is routed straight to clear-to-send. A separate carrier-control input, instead of the request, then decides whether the modulator's transmit carrier is enabled.

Top module: `rts_cts_delay`

## Requirements
- R1: `tick_o` is high for exactly one clock in every 2^PRESCALE_W clocks. It is first high on the clock where the free-running prescaler, cleared by reset, reaches all ones.
- R2: In timer mode (select 2'b00, no loop test), after `rts_n` falls `cts_n` falls on the clock that follows the 350th tick seen while `rts_n` stays low. This gives about 400 ms at the nominal tick rate.
- R3: The low-band table (STANDARD=0) uses 26 ticks for select 2'b01 and 306 ticks for select 2'b10.
- R4: The high-band table (STANDARD=1) uses 175 ticks for select 2'b00. The reserved selects 2'b01 and 2'b10 behave exactly as 2'b00.
- R5: In timer mode, `rts_n` high forces `cts_n` high in the same cycle and clears the count. A later request waits the full delay again, even if the earlier one was dropped part-way.
- R6: With select 2'b11 and no loop test, `cts_n` equals `ext_rts_n` in the same cycle.
- R7: With `loop_test` high, `cts_n` equals `rts_n` in the same cycle, whatever the select value.
- R8: `tx_carrier_en` equals `!rts_n` when `loop_test` is low, and equals `carrier_ctl` when `loop_test` is high.
- R9: During and right after reset, with `rts_n` high, `cts_n` is high and `tx_carrier_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| rts_n | input | 1 | Request to send, active low |
| dly_sel | input | 2 | Delay select; 2'b11 selects the external delay path |
| ext_rts_n | input | 1 | Externally delayed request, active low |
| loop_test | input | 1 | Digital loop-test enable, active high |
| carrier_ctl | input | 1 | Carrier control used in loop test, high enables the carrier |
| cts_n | output | 1 | Clear to send, active low |
| tx_carrier_en | output | 1 | Transmit carrier enable to the modulator |
| tick_o | output | 1 | Slow timing enable, one clock wide |

## Verification
A count register that is not cleared when the request drops shows up on the next request as a clear-to-send that arrives too early. The bench sees this within one tick period, because it compares the number of ticks before the falling edge with the table value. A prescaler phase error shows on `tick_o` at the first expected tick, within 2^PRESCALE_W clocks of reset. A wrong routing choice for loop test, bypass or carrier shows on `cts_n` or `tx_carrier_en` in the same cycle as the input change, because the bench's reference model is compared on every clock.

// File: rtl/rtscts_pkg.sv
package rtscts_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_MID   = 2'b10,
    SEL_EXT   = 2'b11
  } dly_sel_e;
endpackage

// File: rtl/rtscts_tick_gen.sv
module rtscts_tick_gen #(
  parameter int PRESCALE_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PRESCALE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = &pre_q;

  // R1: the enable is never two clocks wide
  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rtscts_on_timer.sv
module rtscts_on_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rts_n,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (rts_n) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_inc >= {1'b0, limit}) done_d = 1'b1;
      else                          cnt_d  = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R2: completion only ever follows a tick
  a_r2_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(tick));
  // R5: a withdrawn request leaves no completed delay behind
  a_r5_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n |=> !done_q);
endmodule

// File: rtl/rts_cts_delay.sv
module rts_cts_delay
  import rtscts_pkg::*;
#(
  parameter int PRESCALE_W = 12,
  parameter int STANDARD   = 0,
  parameter int LIM_LO_00  = 350,
  parameter int LIM_LO_01  = 26,
  parameter int LIM_LO_10  = 306,
  parameter int LIM_HI_00  = 175
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rts_n,
  input  logic [1:0] dly_sel,
  input  logic       ext_rts_n,
  input  logic       loop_test,
  input  logic       carrier_ctl,
  output logic       cts_n,
  output logic       tx_carrier_en,
  output logic       tick_o
);
  localparam int LIM_MAX = (LIM_LO_00 > LIM_LO_10) ? LIM_LO_00 : LIM_LO_10;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic             tick;
  logic             done;
  logic [CNT_W-1:0] limit;
  dly_sel_e         sel;

  assign sel = dly_sel_e'(dly_sel);

  rtscts_tick_gen #(.PRESCALE_W(PRESCALE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    if (STANDARD == 0) begin : g_low_band
      always_comb begin
        unique case (sel)
          SEL_SHORT: limit = CNT_W'(LIM_LO_01);
          SEL_MID:   limit = CNT_W'(LIM_LO_10);
          default:   limit = CNT_W'(LIM_LO_00);
        endcase
      end
    end else begin : g_high_band
      assign limit = CNT_W'(LIM_HI_00);
    end
  endgenerate

  rtscts_on_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rts_n(rts_n),
    .limit(limit), .done(done)
  );

  always_comb begin
    if (loop_test)            cts_n = rts_n;
    else if (sel == SEL_EXT)  cts_n = ext_rts_n;
    else                      cts_n = rts_n | ~done;
  end

  assign tx_carrier_en = loop_test ? carrier_ctl : ~rts_n;
  assign tick_o        = tick;

  // R2: in timer mode clear-to-send only asserts after the timer completes
  a_r2_cts_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_test && sel != SEL_EXT && !cts_n) |-> done);
  // R5: in timer mode a high request always holds clear-to-send off
  a_r5_cts_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_test && sel != SEL_EXT && rts_n) |-> cts_n);
  // R8: outside loop test the carrier follows the request
  a_r8_carrier_req: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_test |-> (tx_carrier_en != rts_n));
endmodule

// File: tb/sim_rts_cts_delay.sv
module sim_rts_cts_delay;
  localparam int PW   = 3;
  localparam int PMOD = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rts_n = 1'b1;
  logic [1:0] dly_sel = 2'b00;
  logic ext_rts_n = 1'b1;
  logic loop_test = 1'b0;
  logic carrier_ctl = 1'b0;
  logic cts0, cts1, txe0, txe1, tk0, tk1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rts_cts_delay #(.PRESCALE_W(PW), .STANDARD(0)) u0 (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .dly_sel(dly_sel),
    .ext_rts_n(ext_rts_n), .loop_test(loop_test), .carrier_ctl(carrier_ctl),
    .cts_n(cts0), .tx_carrier_en(txe0), .tick_o(tk0));

  rts_cts_delay #(.PRESCALE_W(PW), .STANDARD(1)) u1 (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .dly_sel(dly_sel),
    .ext_rts_n(ext_rts_n), .loop_test(loop_test), .carrier_ctl(carrier_ctl),
    .cts_n(cts1), .tx_carrier_en(txe1), .tick_o(tk1));

  // behavioural reference
  int pre = 0;
  int cnt [2] = '{0, 0};
  bit done [2] = '{0, 0};

  function automatic int lim(int v, logic [1:0] s);
    if (v == 1) return 175;
    case (s)
      2'b01:   return 26;
      2'b10:   return 306;
      default: return 350;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pre = 0;
      for (int v = 0; v < 2; v++) begin cnt[v] = 0; done[v] = 0; end
    end else begin
      bit tk;
      tk = (pre == PMOD - 1);
      for (int v = 0; v < 2; v++) begin
        if (rts_n) begin
          cnt[v] = 0; done[v] = 0;
        end else if (tk && !done[v]) begin
          cnt[v]++;
          if (cnt[v] >= lim(v, dly_sel)) done[v] = 1;
        end
      end
      pre = (pre + 1) % PMOD;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      logic e0, e1, et;
      string tg;
      e0 = loop_test ? rts_n : (dly_sel == 2'b11) ? ext_rts_n : (rts_n | !done[0]);
      e1 = loop_test ? rts_n : (dly_sel == 2'b11) ? ext_rts_n : (rts_n | !done[1]);
      et = loop_test ? carrier_ctl : !rts_n;
      tg = loop_test ? "R7" : (dly_sel == 2'b11) ? "R6" : rts_n ? "R5" : "R2";
      if (!rst_n) tg = "R9";
      check(tg, cts0, e0);
      check((tg == "R2") ? "R4" : tg, cts1, e1);
      check("R8", txe0, et);
      check("R8", txe1, et);
      check("R1", tk0, (pre == PMOD - 1));
      check("R1", tk1, (pre == PMOD - 1));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // counts ticks seen before clear-to-send falls on the chosen instance
  task automatic measure(input int which, output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ((which == 0 ? cts0 : cts1) == 1'b0) break;
      if (tk0) n++;
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int n;
    step(3);
    check("R9", cts0, 1'b1);
    check("R9", txe0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step(2);
    check("R9", cts0, 1'b1);

    // R2: long delay, low-band table
    dly_sel = 2'b00; rts_n = 1'b0;
    measure(0, n);
    checks++; if (n != 350) begin errors++; $display("FAIL R2 actual=%0d expected=350", n); end
    step(5);
    rts_n = 1'b1; #1;
    check("R5", cts0, 1'b1);
    step(3);

    // R3: short and mid entries
    dly_sel = 2'b01; rts_n = 1'b0;
    measure(0, n);
    checks++; if (n != 26) begin errors++; $display("FAIL R3 actual=%0d expected=26", n); end
    step(2); rts_n = 1'b1; step(4);
    dly_sel = 2'b10; rts_n = 1'b0;
    measure(0, n);
    checks++; if (n != 306) begin errors++; $display("FAIL R3 actual=%0d expected=306", n); end
    step(2); rts_n = 1'b1; step(4);

    // R4: reserved select on the high-band table
    dly_sel = 2'b01; rts_n = 1'b0;
    measure(1, n);
    checks++; if (n != 175) begin errors++; $display("FAIL R4 actual=%0d expected=175", n); end
    step(2); rts_n = 1'b1; step(4);

    // R5: abort part-way, then a full restart
    dly_sel = 2'b01; rts_n = 1'b0;
    step(20 * PMOD);
    rts_n = 1'b1; step(3);
    rts_n = 1'b0;
    measure(0, n);
    checks++; if (n != 26) begin errors++; $display("FAIL R5 actual=%0d expected=26", n); end
    rts_n = 1'b1; step(4);

    // R6: external delay path
    dly_sel = 2'b11; rts_n = 1'b0; step(3);
    check("R6", cts0, 1'b1);
    ext_rts_n = 1'b0; #1;
    check("R6", cts0, 1'b0);
    step(5); ext_rts_n = 1'b1; #1;
    check("R6", cts0, 1'b1);
    rts_n = 1'b1; step(3);

    // R7 / R8: loop test
    loop_test = 1'b1; dly_sel = 2'b00;
    rts_n = 1'b0; #1;
    check("R7", cts0, 1'b0);
    check("R8", txe0, 1'b0);
    carrier_ctl = 1'b1; #1;
    check("R8", txe0, 1'b1);
    rts_n = 1'b1; #1;
    check("R7", cts0, 1'b1);
    check("R8", txe0, 1'b1);
    step(10);
    loop_test = 1'b0; carrier_ctl = 1'b0; step(10);
    report();
  end
endmodule